// File: doc/BRIEF.md
# SPI Command Engine Register Front End

This block is the memory-mapped control and status face of a command-driven SPI controller. Software reaches it over a simple single-cycle register bus with 32-bit data and byte addresses aligned to words. It decodes each access. Command words and transmit bytes are forwarded as push strobes to two FIFOs, and receive bytes are taken from a third FIFO as pop strobes. It reports how much free space or stored data each FIFO holds. It also collects four interrupt causes into one interrupt line.

The three FIFOs and the SPI execution core sit outside this block. The FIFOs report their occupancy and, for the receive side, their head byte through plain level and data ports. The execution core signals a sync event with an 8-bit tag, and this block latches that tag so software can tell which command program has finished. A soft-reset register drives a hold signal for the core and the FIFOs. Software reads the pending register to find interrupt causes and clears them by writing ones.

Top module: `spi_regfront`

## Requirements
- R1: After `rst_n` is released, `irq` is 0, and reads return 0 for the enable, pending, source and sync-tag registers and 1 for the soft-reset register (offset 0x40, bit 0); `core_reset` is 1.
- R2: A read of offset 0x00 returns major version 1 in bits 23:16, the minor parameter in bits 15:8, the patch parameter in bits 7:0 and zero in bits 31:24. Writes to it have no effect.
- R3: Writing offset 0x40 stores bit 0, which drives `core_reset` from the next cycle and reads back in bit 0.
- R4: Offsets 0xD0 and 0xD4 read the free entries of the command and transmit FIFOs (depth minus level). Offset 0xD8 reads the stored entries of the receive FIFO.
- R5: A write to 0xE0 pulses `cmd_push` with `cmd_wdata` = write data bits 15:0. A write to 0xE4 pulses `sdo_push` with `sdo_wdata` = bits 7:0. Either push is suppressed when that FIFO's level equals its depth.
- R6: Interrupt bits are: bit 0 command FIFO almost empty (level <= command threshold), bit 1 transmit FIFO almost empty (level <= transmit threshold), bit 2 receive FIFO almost full (level >= receive threshold) and bit 3 sync event. A source whose condition is true in a cycle sets its pending bit (offset 0x84) at the following edge, whatever the enable register holds.
- R7: Writing offset 0x84 clears each pending bit written as 1 and leaves the others. A set in the same cycle wins over the clear.
- R8: Offset 0x80 holds a 4-bit enable. Offset 0x88 reads pending AND enable. `irq` is high exactly when that value is non-zero.
- R9: A cycle with `sync_evt` high stores `sync_id_in` into the sync-tag register (offset 0xC0, bits 7:0) and sets pending bit 3.
- R10: A read of 0xE8 returns `sdi_head` and pulses `sdi_pop` once. A read of 0xEC returns `sdi_head` without a pop. When the receive level is 0, both reads return 0 and no pop occurs.
- R11: A read of an unmapped or misaligned address returns 0. Read data appears on `bus_rdata` after the edge that takes the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Registered read data |
| core_reset | output | 1 | Hold for execution core and FIFOs |
| irq | output | 1 | Interrupt request |
| sync_evt | input | 1 | Sync event from the core |
| sync_id_in | input | 8 | Tag carried by the sync event |
| cmd_push | output | 1 | Command FIFO push |
| cmd_wdata | output | 16 | Command word |
| cmd_level | input | CMD_LW | Command FIFO occupancy |
| sdo_push | output | 1 | Transmit FIFO push |
| sdo_wdata | output | 8 | Transmit byte |
| sdo_level | input | SDO_LW | Transmit FIFO occupancy |
| sdi_pop | output | 1 | Receive FIFO pop |
| sdi_head | input | 8 | Receive FIFO head byte |
| sdi_level | input | SDI_LW | Receive FIFO occupancy |

## Verification
FIFO levels are held at mid, full, empty and threshold values while pushes, pops and peeks are issued. This shows that suppression depends on level and not on the strobe alone, and that a peek differs from a pop only in the pop strobe. Interrupt causes are raised by moving levels across thresholds and by sync pulses, under a zero enable and under a one-hot enable. This separates the pending path from the masked source and `irq` paths. Write-one-clear is tried both while a cause has gone away and while it is still active, so that clear and set priority can be told apart.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

  localparam int NUM_IRQ = 4;
  localparam int IRQ_CMD_LOW  = 0;
  localparam int IRQ_SDO_LOW  = 1;
  localparam int IRQ_SDI_HIGH = 2;
  localparam int IRQ_SYNC     = 3;

  localparam logic [7:0] VER_MAJOR = 8'd1;

  // word indices (byte offset / 4)
  localparam logic [5:0] W_VERSION  = 6'd0;
  localparam logic [5:0] W_SOFTRST  = 6'd16;
  localparam logic [5:0] W_IEN      = 6'd32;
  localparam logic [5:0] W_IPEND    = 6'd33;
  localparam logic [5:0] W_ISRC     = 6'd34;
  localparam logic [5:0] W_SYNCTAG  = 6'd48;
  localparam logic [5:0] W_CMD_ROOM = 6'd52;
  localparam logic [5:0] W_SDO_ROOM = 6'd53;
  localparam logic [5:0] W_SDI_LVL  = 6'd54;
  localparam logic [5:0] W_CMD_DATA = 6'd56;
  localparam logic [5:0] W_SDO_DATA = 6'd57;
  localparam logic [5:0] W_SDI_POP  = 6'd58;
  localparam logic [5:0] W_SDI_PEEK = 6'd59;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_VERSION,
    SEL_SOFTRST,
    SEL_IEN,
    SEL_IPEND,
    SEL_ISRC,
    SEL_SYNCTAG,
    SEL_CMD_ROOM,
    SEL_SDO_ROOM,
    SEL_SDI_LVL,
    SEL_CMD_DATA,
    SEL_SDO_DATA,
    SEL_SDI_POP,
    SEL_SDI_PEEK
  } reg_sel_e;

endpackage

// File: rtl/spireg_decode.sv
module spireg_decode
  import spireg_pkg::*;
(
  input  logic [7:0] addr,
  output reg_sel_e   sel
);

  always_comb begin
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      case (addr[7:2])
        W_VERSION:  sel = SEL_VERSION;
        W_SOFTRST:  sel = SEL_SOFTRST;
        W_IEN:      sel = SEL_IEN;
        W_IPEND:    sel = SEL_IPEND;
        W_ISRC:     sel = SEL_ISRC;
        W_SYNCTAG:  sel = SEL_SYNCTAG;
        W_CMD_ROOM: sel = SEL_CMD_ROOM;
        W_SDO_ROOM: sel = SEL_SDO_ROOM;
        W_SDI_LVL:  sel = SEL_SDI_LVL;
        W_CMD_DATA: sel = SEL_CMD_DATA;
        W_SDO_DATA: sel = SEL_SDO_DATA;
        W_SDI_POP:  sel = SEL_SDI_POP;
        W_SDI_PEEK: sel = SEL_SDI_PEEK;
        default:    sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/spireg_fifo_port.sv
module spireg_fifo_port #(
  parameter int DEPTH     = 16,
  parameter int THRESH    = 4,
  parameter bit RX_SIDE   = 1'b0,
  localparam int LW       = $clog2(DEPTH + 1)
) (
  input  logic [LW-1:0] level,
  input  logic          req,
  output logic          grant,
  output logic [LW-1:0] room,
  output logic          flag
);

  localparam logic [LW-1:0] DEPTH_V  = LW'(DEPTH);
  localparam logic [LW-1:0] THRESH_V = LW'(THRESH);

  assign room = DEPTH_V - level;

  generate
    if (RX_SIDE) begin : g_rx
      // pop side: needs data, flags when nearly full
      assign grant = req && (level != '0);
      assign flag  = (level >= THRESH_V);
    end else begin : g_tx
      // push side: needs space, flags when nearly empty
      assign grant = req && (level < DEPTH_V);
      assign flag  = (level <= THRESH_V);
    end
  endgenerate

endmodule

// File: rtl/spireg_irq.sv
module spireg_irq #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] cause,
  input  logic            en_wr,
  input  logic            pend_wr,
  input  logic [NSRC-1:0] wbits,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] masked,
  output logic            irq
);

  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] en_d;

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_bit
      always_comb begin
        pend_d[i] = cause[i] | (pend_q[i] & ~(pend_wr & wbits[i]));
      end
    end
  endgenerate

  always_comb begin
    en_d = en_wr ? wbits : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  assign masked = pend_q & en_q;
  assign irq    = |masked;

endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
  import spireg_pkg::*;
#(
  parameter int          CMD_DEPTH = 16,
  parameter int          SDO_DEPTH = 16,
  parameter int          SDI_DEPTH = 16,
  parameter int          CMD_LOW   = CMD_DEPTH / 4,
  parameter int          SDO_LOW   = SDO_DEPTH / 4,
  parameter int          SDI_HIGH  = SDI_DEPTH - SDI_DEPTH / 4,
  parameter logic [7:0]  VER_MINOR = 8'd3,
  parameter logic [7:0]  VER_PATCH = 8'h61,
  localparam int         CMD_LW    = $clog2(CMD_DEPTH + 1),
  localparam int         SDO_LW    = $clog2(SDO_DEPTH + 1),
  localparam int         SDI_LW    = $clog2(SDI_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr_en,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd_en,
  output logic [31:0]       bus_rdata,
  output logic              core_reset,
  output logic              irq,
  input  logic              sync_evt,
  input  logic [7:0]        sync_id_in,
  output logic              cmd_push,
  output logic [15:0]       cmd_wdata,
  input  logic [CMD_LW-1:0] cmd_level,
  output logic              sdo_push,
  output logic [7:0]        sdo_wdata,
  input  logic [SDO_LW-1:0] sdo_level,
  output logic              sdi_pop,
  input  logic [7:0]        sdi_head,
  input  logic [SDI_LW-1:0] sdi_level
);

  reg_sel_e sel;

  logic [CMD_LW-1:0]  cmd_room;
  logic [SDO_LW-1:0]  sdo_room;
  logic [SDI_LW-1:0]  sdi_room_unused;
  logic               cmd_low, sdo_low, sdi_high;
  logic               sdi_has_data;

  logic [NUM_IRQ-1:0] cause;
  logic [NUM_IRQ-1:0] pend_q;
  logic [NUM_IRQ-1:0] en_q;
  logic [NUM_IRQ-1:0] masked;

  logic               srst_q, srst_d;
  logic [7:0]         sid_q, sid_d;
  logic [31:0]        rdata_q, rdata_d;
  logic               wdata_unused;

  assign wdata_unused = ^bus_wdata[31:16];

  spireg_decode u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  spireg_fifo_port #(.DEPTH(CMD_DEPTH), .THRESH(CMD_LOW), .RX_SIDE(1'b0)) u_cmd (
    .level (cmd_level),
    .req   (bus_wr_en && (sel == SEL_CMD_DATA)),
    .grant (cmd_push),
    .room  (cmd_room),
    .flag  (cmd_low)
  );

  spireg_fifo_port #(.DEPTH(SDO_DEPTH), .THRESH(SDO_LOW), .RX_SIDE(1'b0)) u_sdo (
    .level (sdo_level),
    .req   (bus_wr_en && (sel == SEL_SDO_DATA)),
    .grant (sdo_push),
    .room  (sdo_room),
    .flag  (sdo_low)
  );

  spireg_fifo_port #(.DEPTH(SDI_DEPTH), .THRESH(SDI_HIGH), .RX_SIDE(1'b1)) u_sdi (
    .level (sdi_level),
    .req   (bus_rd_en && (sel == SEL_SDI_POP)),
    .grant (sdi_pop),
    .room  (sdi_room_unused),
    .flag  (sdi_high)
  );

  assign cmd_wdata    = bus_wdata[15:0];
  assign sdo_wdata    = bus_wdata[7:0];
  assign sdi_has_data = (sdi_level != '0);

  always_comb begin
    cause               = '0;
    cause[IRQ_CMD_LOW]  = cmd_low;
    cause[IRQ_SDO_LOW]  = sdo_low;
    cause[IRQ_SDI_HIGH] = sdi_high;
    cause[IRQ_SYNC]     = sync_evt;
  end

  spireg_irq #(.NSRC(NUM_IRQ)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cause   (cause),
    .en_wr   (bus_wr_en && (sel == SEL_IEN)),
    .pend_wr (bus_wr_en && (sel == SEL_IPEND)),
    .wbits   (bus_wdata[NUM_IRQ-1:0]),
    .pend_q  (pend_q),
    .en_q    (en_q),
    .masked  (masked),
    .irq     (irq)
  );

  // next-state logic for local registers
  always_comb begin
    srst_d = srst_q;
    if (bus_wr_en && (sel == SEL_SOFTRST)) begin
      srst_d = bus_wdata[0];
    end
    sid_d = sync_evt ? sync_id_in : sid_q;
  end

  // read data mux
  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_VERSION:  rdata_d = {8'd0, VER_MAJOR, VER_MINOR, VER_PATCH};
      SEL_SOFTRST:  rdata_d = {31'd0, srst_q};
      SEL_IEN:      rdata_d = 32'(en_q);
      SEL_IPEND:    rdata_d = 32'(pend_q);
      SEL_ISRC:     rdata_d = 32'(masked);
      SEL_SYNCTAG:  rdata_d = {24'd0, sid_q};
      SEL_CMD_ROOM: rdata_d = 32'(cmd_room);
      SEL_SDO_ROOM: rdata_d = 32'(sdo_room);
      SEL_SDI_LVL:  rdata_d = 32'(sdi_level);
      SEL_SDI_POP,
      SEL_SDI_PEEK: rdata_d = sdi_has_data ? {24'd0, sdi_head} : 32'd0;
      default:      rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b1;
      sid_q  <= '0;
    end else begin
      srst_q <= srst_d;
      sid_q  <= sid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign core_reset = srst_q;

endmodule

// File: rtl/spi_regfront_chk.sv
module spi_regfront_chk #(
  parameter int CMD_DEPTH = 16,
  parameter int CMD_LOW   = 4,
  parameter int CMD_LW    = 5,
  parameter int SDI_LW    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd_en,
  input logic              cmd_push,
  input logic [CMD_LW-1:0] cmd_level,
  input logic              sdi_pop,
  input logic [SDI_LW-1:0] sdi_level,
  input logic              sync_evt,
  input logic [7:0]        sync_id_in,
  input logic [7:0]        sid_q,
  input logic [3:0]        pend_q,
  input logic [3:0]        en_q,
  input logic              irq
);

  a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_push |-> (cmd_level < CMD_LW'(CMD_DEPTH)));

  a_r10_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    sdi_pop |-> (sdi_level != '0));

  a_r10_pop_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    sdi_pop |-> bus_rd_en);

  a_r9_tag_latched: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> (sid_q == $past(sync_id_in)));

  a_r9_sync_pending: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> pend_q[3]);

  a_r6_cmd_low_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_level <= CMD_LW'(CMD_LOW)) |=> pend_q[0]);

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 4'd0) |-> !irq);

endmodule

bind spi_regfront spi_regfront_chk #(
  .CMD_DEPTH (CMD_DEPTH),
  .CMD_LOW   (CMD_LOW),
  .CMD_LW    (CMD_LW),
  .SDI_LW    (SDI_LW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_rd_en  (bus_rd_en),
  .cmd_push   (cmd_push),
  .cmd_level  (cmd_level),
  .sdi_pop    (sdi_pop),
  .sdi_level  (sdi_level),
  .sync_evt   (sync_evt),
  .sync_id_in (sync_id_in),
  .sid_q      (sid_q),
  .pend_q     (pend_q),
  .en_q       (en_q),
  .irq        (irq)
);

// File: tb/tb_spi_regfront.sv
module tb_spi_regfront;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int LW = 5;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr_en;
  logic [31:0] bus_wdata;
  logic        bus_rd_en;
  logic [31:0] bus_rdata;
  logic        core_reset;
  logic        irq;
  logic        sync_evt;
  logic [7:0]  sync_id_in;
  logic        cmd_push;
  logic [15:0] cmd_wdata;
  logic [LW-1:0] cmd_level;
  logic        sdo_push;
  logic [7:0]  sdo_wdata;
  logic [LW-1:0] sdo_level;
  logic        sdi_pop;
  logic [7:0]  sdi_head;
  logic [LW-1:0] sdi_level;

  int n_checks = 0;
  int n_fails  = 0;
  int cmd_pushes = 0;
  int sdo_pushes = 0;
  int sdi_pops   = 0;
  logic [15:0] last_cmd;
  logic [7:0]  last_sdo;

  spi_regfront dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .core_reset(core_reset), .irq(irq), .sync_evt(sync_evt),
    .sync_id_in(sync_id_in), .cmd_push(cmd_push), .cmd_wdata(cmd_wdata),
    .cmd_level(cmd_level), .sdo_push(sdo_push), .sdo_wdata(sdo_wdata),
    .sdo_level(sdo_level), .sdi_pop(sdi_pop), .sdi_head(sdi_head),
    .sdi_level(sdi_level)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (cmd_push) begin cmd_pushes++; last_cmd = cmd_wdata; end
    if (sdo_push) begin sdo_pushes++; last_sdo = sdo_wdata; end
    if (sdi_pop)  sdi_pops++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 core_reset", 32'(core_reset), 32'd1);
    rd(8'h80, v); check("R1 enable", v, 32'd0);
    rd(8'h84, v); check("R1 pending", v, 32'd0);
    rd(8'h88, v); check("R1 source", v, 32'd0);
    rd(8'hC0, v); check("R1 synctag", v, 32'd0);
    rd(8'h40, v); check("R1 softreset", v, 32'd1);
  endtask

  task automatic t_version();
    logic [31:0] v;
    rd(8'h00, v); check("R2 version", v, 32'h0001_0361);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R2 version ro", v, 32'h0001_0361);
  endtask

  task automatic t_softreset();
    logic [31:0] v;
    wr(8'h40, 32'd0);
    check("R3 release", 32'(core_reset), 32'd0);
    rd(8'h40, v); check("R3 readback0", v, 32'd0);
    wr(8'h40, 32'd1);
    check("R3 hold", 32'(core_reset), 32'd1);
    wr(8'h40, 32'd0);
  endtask

  task automatic t_levels();
    logic [31:0] v;
    cmd_level = 5'd5; sdo_level = 5'd16; sdi_level = 5'd9;
    rd(8'hD0, v); check("R4 cmd room", v, 32'd11);
    rd(8'hD4, v); check("R4 sdo room full", v, 32'd0);
    rd(8'hD8, v); check("R4 sdi level", v, 32'd9);
    cmd_level = 5'd8; sdo_level = 5'd8; sdi_level = 5'd0;
  endtask

  task automatic t_push();
    int c0, s0;
    c0 = cmd_pushes; s0 = sdo_pushes;
    wr(8'hE0, 32'hDEAD_1234);
    check("R5 cmd push", 32'(cmd_pushes - c0), 32'd1);
    check("R5 cmd data", 32'(last_cmd), 32'h1234);
    cmd_level = 5'd16;
    wr(8'hE0, 32'h0000_5555);
    check("R5 cmd full drop", 32'(cmd_pushes - c0), 32'd1);
    cmd_level = 5'd8;
    sdo_level = 5'd16;
    wr(8'hE4, 32'h0000_00AA);
    check("R5 sdo full drop", 32'(sdo_pushes - s0), 32'd0);
    sdo_level = 5'd10;
    wr(8'hE4, 32'h0000_01C3);
    check("R5 sdo push", 32'(sdo_pushes - s0), 32'd1);
    check("R5 sdo data", 32'(last_sdo), 32'hC3);
    sdo_level = 5'd8;
  endtask

  task automatic t_pending();
    logic [31:0] v;
    wr(8'h84, 32'hFF);
    rd(8'h84, v); check("R7 all clear", v, 32'd0);
    @(negedge clk); cmd_level = 5'd4;
    @(negedge clk); cmd_level = 5'd8;
    rd(8'h84, v); check("R6 cmd low at threshold", v, 32'h1);
    sdi_level = 5'd12;
    @(negedge clk); sdi_level = 5'd0;
    rd(8'h84, v); check("R6 sdi high", v, 32'h5);
    check("R8 irq masked", 32'(irq), 32'd0);
    wr(8'h84, 32'h4);
    rd(8'h84, v); check("R7 partial clear", v, 32'h1);
    sdo_level = 5'd5;
    @(negedge clk);
    rd(8'h84, v); check("R6 sdo above threshold", v, 32'h1);
    sdo_level = 5'd2;
    wr(8'h84, 32'h2);
    rd(8'h84, v); check("R7 set wins over clear", v, 32'h3);
    sdo_level = 5'd8;
    wr(8'h84, 32'hFF);
    rd(8'h84, v); check("R7 cleared", v, 32'd0);
  endtask

  task automatic t_sync_irq();
    logic [31:0] v;
    @(negedge clk); sync_evt = 1'b1; sync_id_in = 8'h5C;
    @(negedge clk); sync_evt = 1'b0; sync_id_in = 8'h00;
    rd(8'hC0, v); check("R9 tag", v, 32'h5C);
    rd(8'h84, v); check("R9 pending bit3", v, 32'h8);
    check("R8 irq off when disabled", 32'(irq), 32'd0);
    rd(8'h88, v); check("R8 source masked", v, 32'd0);
    wr(8'h80, 32'h8);
    check("R8 irq on", 32'(irq), 32'd1);
    rd(8'h88, v); check("R8 source", v, 32'h8);
    rd(8'h80, v); check("R8 enable rb", v, 32'h8);
    wr(8'h84, 32'h8);
    check("R8 irq after clear", 32'(irq), 32'd0);
    wr(8'h80, 32'h0);
  endtask

  task automatic t_pop();
    logic [31:0] v;
    int p0;
    p0 = sdi_pops;
    sdi_level = 5'd3; sdi_head = 8'hA7;
    rd(8'hE8, v); check("R10 pop data", v, 32'hA7);
    check("R10 pop count", 32'(sdi_pops - p0), 32'd1);
    rd(8'hEC, v); check("R10 peek data", v, 32'hA7);
    check("R10 peek no pop", 32'(sdi_pops - p0), 32'd1);
    sdi_level = 5'd0;
    rd(8'hE8, v); check("R10 empty data", v, 32'd0);
    check("R10 empty no pop", 32'(sdi_pops - p0), 32'd1);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(8'h10, v); check("R11 unmapped", v, 32'd0);
    rd(8'h41, v); check("R11 misaligned", v, 32'd0);
    sdi_level = 5'd9;
    rd(8'hD8, v);
    repeat (3) @(negedge clk);
    check("R11 hold", bus_rdata, 32'd9);
    sdi_level = 5'd0;
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr_en = 1'b0; bus_wdata = '0;
    bus_rd_en = 1'b0; sync_evt = 1'b0; sync_id_in = '0;
    cmd_level = 5'd8; sdo_level = 5'd8; sdi_level = 5'd0; sdi_head = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_version();
    t_softreset();
    t_levels();
    t_push();
    t_pending();
    t_sync_irq();
    t_pop();
    t_unmapped();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule